// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the oversampling enable for one serial channel. It runs entirely on a reference clock. A prescaler divides the reference either by one or by a slower fixed factor. Its enables then drive a divider with a 16-bit integer part and a fraction in sixteenths. The fraction is realised by stretching selected periods by one prescaled cycle. A phase accumulator picks those periods, so that the long periods in every run of sixteen ticks are spread as evenly as possible.

The main output, `sampleTick`, is a one-cycle enable that the transmitter and the receiver share. A second output, `bitTick`, rises together with every 16th, 8th or 4th sample tick, depending on the selected oversampling ratio. A small write-only register port holds the settings. Every write to that port restarts the timing from a clean phase.

Top module: `fracBaudGen`

## Requirements
- R1: After reset the integer divisor is 0, the fraction is 0, the ratio is 16x and the prescaler divides by 1, so neither `sampleTick` nor `bitTick` is ever high until a register is written.
- R2: With prescale by 1, integer divisor N ≥ 1 and fraction 0, `sampleTick` is a single-cycle pulse. The first pulse comes exactly N reference cycles after the clock edge that takes the last register write, and later pulses repeat every N cycles.
- R3: Bit 0 of register 3 set to 1 selects prescale by 4. All tick intervals, including the first one after a write, are then 4 times longer.
- R4: An integer divisor of 0 stops all ticks, whatever the fraction holds.
- R5: With fraction F (0..15), period k after a restart (k counted from 1) lasts N+1 prescaled cycles when floor(k·F/16) > floor((k−1)·F/16), and N cycles otherwise. Every 16 consecutive periods therefore contain exactly F long ones.
- R6: Register 2 bits [5:4] select the ratio: 00 gives 16, 01 gives 8, 10 gives 4 and 11 gives 16. `bitTick` is high only together with a `sampleTick`, on every ratio-th tick counted from the last write.
- R7: A write to any register clears the prescaler, the divider count, the fraction phase and the ratio count. The new settings then apply from a full first period, which is always a short one.
- R8: The register addresses are: 0 holds the low byte of the integer divisor, 1 the high byte, 2 the fraction in bits [3:0] together with the ratio field, and 3 the prescale select.
- R9: With prescale by 1 and an integer divisor of 1, `sampleTick` stays high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| sampleTick | output | 1 | Oversampling enable, one cycle per period |
| bitTick | output | 1 | Bit-rate enable, coincident with a sample tick |

## Verification
The bench builds the block with its default parameters: a 16-bit integer divisor, a 4-bit fraction and a slow prescale factor of 4. With these values a divisor of 258 exercises the high byte, and a full fraction sequence of 33 periods can be checked edge by edge against the floor formula. The prescaler and all three ratio encodings, plus the alias 11, are reached within a few hundred cycles. Restart is checked both in the middle of an integer period and in the middle of the fraction phase.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  typedef enum logic [1:0] {
    OS_X16  = 2'b00,
    OS_X8   = 2'b01,
    OS_X4   = 2'b10,
    OS_X16B = 2'b11
  } osMode_e;

  typedef struct packed {
    logic restart;
  } ctrlStrobe_t;

  localparam logic [1:0] ADDR_DIV_LO = 2'd0;
  localparam logic [1:0] ADDR_DIV_HI = 2'd1;
  localparam logic [1:0] ADDR_FRAC   = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;
  localparam int         MODE_LSB    = 4;

endpackage

// File: rtl/fbgControl.sv
module fbgControl
  import fbg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [7:0]        wrData,
  output logic [DIV_W-1:0]  divN,
  output logic [FRAC_W-1:0] fracVal,
  output osMode_e           osMode,
  output logic              slowSel,
  output ctrlStrobe_t       strobe
);

  localparam int HI_W = DIV_W - 8;

  logic [7:0]      divLo;
  logic [HI_W-1:0] divHi;
  logic [1:0]      modeBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLo    <= '0;
      divHi    <= '0;
      fracVal  <= '0;
      modeBits <= 2'b00;
      slowSel  <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_DIV_LO: divLo <= wrData;
        ADDR_DIV_HI: divHi <= wrData[HI_W-1:0];
        ADDR_FRAC: begin
          fracVal  <= wrData[FRAC_W-1:0];
          modeBits <= wrData[MODE_LSB+1:MODE_LSB];
        end
        ADDR_CTRL:   slowSel <= wrData[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    divN           = {divHi, divLo};
    osMode         = osMode_e'(modeBits);
    strobe.restart = wrEn;
  end

  p_low_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_DIV_LO) |=> (divN[7:0] == $past(wrData)));

  p_prescale_sel_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CTRL) |=> (slowSel == $past(wrData[0])));

endmodule

// File: rtl/fbgDatapath.sv
module fbgDatapath
  import fbg_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int FRAC_W   = 4,
  parameter int SLOW_PRE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DIV_W-1:0]  divN,
  input  logic [FRAC_W-1:0] fracVal,
  input  osMode_e           osMode,
  input  logic              slowSel,
  output logic              sampleTick,
  output logic              bitTick
);

  localparam int PRE_W = (SLOW_PRE > 2) ? $clog2(SLOW_PRE) : 1;
  localparam int OS_W  = 4;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOW_PRE - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [DIV_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [OS_W-1:0]   osCnt;

  logic              preEn;
  logic              active;
  logic              longNow;
  logic [FRAC_W:0]   accSum;
  logic [DIV_W-1:0]  lastCnt;
  logic              hit;
  logic [OS_W-1:0]   osLast;

  always_comb begin
    preEn   = slowSel ? (preCnt == PRE_LAST) : 1'b1;
    active  = (divN != '0);
    accSum  = {1'b0, acc} + {1'b0, fracVal};
    longNow = accSum[FRAC_W];
    lastCnt = divN - DIV_W'(1) + DIV_W'(longNow);
    hit     = active && preEn && (cnt == lastCnt);
    case (osMode)
      OS_X8:   osLast = OS_W'(7);
      OS_X4:   osLast = OS_W'(3);
      default: osLast = OS_W'(15);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt     <= '0;
      cnt        <= '0;
      acc        <= '0;
      osCnt      <= '0;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else if (strobe.restart) begin
      preCnt     <= '0;
      cnt        <= '0;
      acc        <= '0;
      osCnt      <= '0;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else begin
      if (slowSel) preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + PRE_W'(1);
      else         preCnt <= '0;
      if (active && preEn) cnt <= hit ? '0 : cnt + DIV_W'(1);
      if (hit) begin
        acc   <= accSum[FRAC_W-1:0];
        osCnt <= (osCnt == osLast) ? '0 : osCnt + OS_W'(1);
      end
      sampleTick <= hit;
      bitTick    <= hit && (osCnt == osLast);
    end
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && !slowSel && divN > DIV_W'(1) && !strobe.restart) |=> !sampleTick);

  p_pre_space_r3: assert property (@(posedge clk) disable iff (!rstN)
    (slowSel && preEn && !strobe.restart) |=> !preEn);

  p_quiet_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (divN == '0) |=> (!sampleTick && !bitTick));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (cnt <= lastCnt));

  p_bit_with_sample_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick);

  p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (!sampleTick && cnt == '0 && acc == '0));

endmodule

// File: rtl/fracBaudGen.sv
module fracBaudGen
  import fbg_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int FRAC_W   = 4,
  parameter int SLOW_PRE = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       sampleTick,
  output logic       bitTick
);

  logic [DIV_W-1:0]  divN;
  logic [FRAC_W-1:0] fracVal;
  osMode_e           osMode;
  logic              slowSel;
  ctrlStrobe_t       strobe;

  fbgControl #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .divN    (divN),
    .fracVal (fracVal),
    .osMode  (osMode),
    .slowSel (slowSel),
    .strobe  (strobe)
  );

  fbgDatapath #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .SLOW_PRE(SLOW_PRE)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .divN       (divN),
    .fracVal    (fracVal),
    .osMode     (osMode),
    .slowSel    (slowSel),
    .sampleTick (sampleTick),
    .bitTick    (bitTick)
  );

endmodule

// File: tb/test_fracBaudGen.sv
module test_fracBaudGen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       sampleTick;
  logic       bitTick;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int wrCyc = 0;
  int nGot = 0;
  int strayBits = 0;
  int tickAt [0:63];
  bit bitAt  [0:63];

  fracBaudGen i_fracBaudGen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrCyc = cyc;
  endtask

  task automatic cfg(input int n, input int f, input int mode, input bit slow);
    wr(2'd0, 8'(n));
    wr(2'd1, 8'(n >> 8));
    wr(2'd2, 8'((mode << 4) | f));
    wr(2'd3, {7'd0, slow});
  endtask

  task automatic collect(input int want, input int limit);
    nGot = 0;
    strayBits = 0;
    for (int i = 0; i < limit && nGot < want; i++) begin
      @(negedge clk);
      if (sampleTick) begin
        tickAt[nGot] = cyc;
        bitAt[nGot]  = bitTick;
        nGot++;
      end else if (bitTick) strayBits++;
    end
  endtask

  function automatic int periodLen(input int n, input int f, input int k);
    return n + ((((k * f) / 16) > (((k - 1) * f) / 16)) ? 1 : 0);
  endfunction

  task automatic checkSeq(input string req, input int want, input int n,
                          input int f, input int p);
    int prev = wrCyc;
    check(nGot == want, req, "tick count", nGot, want);
    for (int k = 0; k < nGot; k++) begin
      int exp = prev + p * periodLen(n, f, k + 1);
      check(tickAt[k] == exp, req, $sformatf("tick %0d cycle", k), tickAt[k], exp);
      prev = exp;
    end
  endtask

  task automatic t_reset();
    collect(1, 200);
    check(nGot == 0, "R1", "ticks after reset", nGot, 0);
    check(strayBits == 0, "R1", "bit ticks after reset", strayBits, 0);
  endtask

  task automatic t_integer();
    cfg(5, 0, 0, 1'b0);
    collect(6, 200);
    checkSeq("R2", 6, 5, 0, 1);
  endtask

  task automatic t_unity();
    cfg(1, 0, 0, 1'b0);
    collect(20, 20);
    checkSeq("R9", 20, 1, 0, 1);
  endtask

  task automatic t_prescale();
    cfg(3, 0, 0, 1'b1);
    collect(5, 200);
    checkSeq("R3", 5, 3, 0, 4);
    cfg(2, 3, 0, 1'b1);
    collect(18, 400);
    checkSeq("R3", 18, 2, 3, 4);
  endtask

  task automatic t_zero();
    cfg(0, 7, 0, 1'b0);
    collect(1, 300);
    check(nGot == 0, "R4", "ticks with zero divisor", nGot, 0);
    check(strayBits == 0, "R4", "bit ticks with zero divisor", strayBits, 0);
  endtask

  task automatic t_fraction();
    int longs = 0;
    cfg(3, 5, 0, 1'b0);
    collect(33, 400);
    checkSeq("R5", 33, 3, 5, 1);
    for (int k = 1; k < 17 && k < nGot; k++)
      if (tickAt[k] - tickAt[k-1] == 4) longs++;
    if (tickAt[0] - wrCyc == 4) longs++;
    check(longs == 5, "R5", "long periods in 16", longs, 5);
    cfg(1, 15, 0, 1'b0);
    collect(20, 100);
    checkSeq("R5", 20, 1, 15, 1);
  endtask

  task automatic t_mode(input int mode, input int ratio);
    int bad = 0;
    cfg(2, 0, mode, 1'b0);
    collect(3 * ratio, 400);
    check(nGot == 3 * ratio, "R6", "ticks in mode run", nGot, 3 * ratio);
    for (int k = 0; k < nGot; k++)
      if (bitAt[k] != (((k + 1) % ratio) == 0)) bad++;
    check(bad == 0, "R6", $sformatf("bit tick placement ratio %0d", ratio), bad, 0);
    check(strayBits == 0, "R6", "bit tick without sample tick", strayBits, 0);
  endtask

  task automatic t_highByte();
    cfg(258, 0, 0, 1'b0);
    collect(2, 700);
    checkSeq("R8", 2, 258, 0, 1);
  endtask

  task automatic t_restart();
    int early = 0;
    cfg(10, 0, 0, 1'b0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (sampleTick) early++;
    end
    wr(2'd0, 8'd4);
    check(early == 0, "R7", "ticks before mid-period write", early, 0);
    collect(3, 100);
    checkSeq("R7", 3, 4, 0, 1);
    cfg(2, 8, 0, 1'b0);
    collect(1, 50);
    check(nGot == 1 && tickAt[0] == wrCyc + 2, "R7", "first period before rewrite",
          tickAt[0] - wrCyc, 2);
    wr(2'd2, 8'd8);
    collect(4, 50);
    checkSeq("R7", 4, 2, 8, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_integer();
    t_unity();
    t_prescale();
    t_zero();
    t_fraction();
    t_mode(0, 16);
    t_mode(1, 8);
    t_mode(2, 4);
    t_mode(3, 16);
    t_highByte();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule